// File: doc/BRIEF.md
# Pipelined Third-Order Fractional Ratio Modulator

This block produces one integer division ratio per reference-clock cycle for a multi-modulus divider whose legal ratios run from 16 to 31. It takes a 20-bit fractional control word and a 5-bit integer base. Three first-order accumulators are chained in cascade. Each accumulator wraps modulo 2^20 and emits a one-bit overflow. The overflows are realigned in time and recombined as c1 + (1 - z^-1)c2 + (1 - z^-1)^2 c3. This gives a signed offset in the range -3 to +4, whose long-run mean equals frac/2^20 and whose quantization error is shaped at third order. The offset is added to the base, and the result is clamped to the divider window.

Every stage reads the registered residue of the stage before it. No adder chain therefore spans more than one 20-bit add per cycle. Delay lines on the first and second overflow streams make up for the extra cycle that each later stage adds. The offset is registered before it meets the base, and the output ratio is registered as well. Bases from 19 to 27 can never leave the window. Any other base raises a saturation flag, and the output is then clamped.

Top module: `mash3_ratio_gen`

## Requirements
- R1: A synchronous active-high reset forces the ratio output to 16 and the saturation flag to 0 at the next clock edge, whatever the other inputs are.
- R2: With a fractional word of 0 held since reset, the ratio output equals the base on every cycle, for any base from 19 to 27.
- R3: For a base from 19 to 27, the ratio minus the base sampled one edge earlier always lies between -3 and +4 inclusive.
- R4: Over 32768 consecutive outputs, the sum of (ratio - base) is within 4 of 32768*frac/2^20.
- R5: With frac = 2^19 held, the output sequence settles to period 4, and any four consecutive offsets sum to exactly 2.
- R6: The saturation flag is 1 exactly when the base sampled at the previous edge is below 19 or above 27. Bases 19 and 27 give 0, and bases 18 and 28 give 1.
- R7: The ratio output never leaves the range 16 to 31. Out-of-window sums are clamped, so base 2 gives a constant 16, and base 31 with frac = 2^19 gives only 30 or 31.
- R8: A change of base appears at the ratio output after exactly one clock edge, and not before that edge.
- R9: With frac = 2^19 and the base applied through reset, the outputs after the first ten edges following reset release are b, b, b, b, b, b+2, b-1, b+1, b, b+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; one ratio per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frac_i | input | 20 | Fractional control word, mean offset = frac_i/2^20 |
| base_i | input | 5 | Integer base ratio |
| ratio_o | output | 5 | Registered division ratio, always 16 to 31 |
| sat_o | output | 1 | Registered flag, base outside 19 to 27 |

## Verification
Suppose the alignment delays or the differencing histories are mis-set. The ratio sequence then shows it within the first ten outputs after reset, because the startup pattern for a half-scale fraction is fixed. It would also break the period-4 pattern and the exact four-sample sum. A broken differencing weight usually pushes the offset outside -3 to +4 within a handful of cycles. A faulty accumulator width or carry instead shows up as a drift in the long-run mean, which grows over thousands of samples. The mean is therefore checked over 32768 outputs for small, mid-range and near-full fractions. Saturation and clamping errors appear on the first edge after an out-of-window base.

// File: rtl/mash_pkg.sv
package mash_pkg;
  localparam int ORDER = 3;
  localparam int OFF_W = 4;
  localparam int OFF_MIN = -3;
  localparam int OFF_MAX = 4;
  typedef logic signed [OFF_W-1:0] off_t;
endpackage

// File: rtl/mash_acc_chain.sv
// Cascade of first-order accumulators; each stage adds the registered
// residue of the stage before it, so one W-bit add sits between flops.
module mash_acc_chain #(
  parameter int W = 20,
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] frac_i,
  output logic [N-1:0] cy_o
);
  for (genvar k = 0; k < N; k++) begin : g_st
    logic [W-1:0] acc_q;
    logic [W-1:0] feed;
    logic [W:0]   sum;
    logic         cy_q;

    if (k == 0) begin : g_in
      assign feed = frac_i;
    end else begin : g_in
      assign feed = g_st[k-1].acc_q;
    end

    assign sum = {1'b0, acc_q} + {1'b0, feed};

    always_ff @(posedge clk) begin
      if (rst) begin
        acc_q <= '0;
        cy_q  <= 1'b0;
      end else begin
        acc_q <= sum[W-1:0];
        cy_q  <= sum[W];
      end
    end

    assign cy_o[k] = cy_q;
  end
endmodule

// File: rtl/mash_cancel.sv
// Aligns the stage overflows and applies the noise-cancelling differences.
module mash_cancel
  import mash_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [ORDER-1:0] cy_i,
  output off_t             off_o
);
  logic [ORDER-1:0] al;

  // stage k lags stage 0 by k cycles, so it is delayed by ORDER-1-k
  for (genvar k = 0; k < ORDER; k++) begin : g_al
    localparam int DLY = ORDER - 1 - k;
    if (DLY == 0) begin : g_pass
      assign al[k] = cy_i[k];
    end else begin : g_dly
      logic [DLY-1:0] sr;
      always_ff @(posedge clk) begin
        if (rst) begin
          sr <= '0;
        end else begin
          sr[0] <= cy_i[k];
          for (int i = 1; i < DLY; i++) sr[i] <= sr[i-1];
        end
      end
      assign al[k] = sr[DLY-1];
    end
  end

  function automatic off_t widen(input logic b);
    return $signed({{(OFF_W-1){1'b0}}, b});
  endfunction

  logic al2_p, al3_p1, al3_p2;
  off_t t1, t2, t3, sum_d;

  always_comb begin
    t1    = widen(al[0]);
    t2    = widen(al[1]) - widen(al2_p);
    t3    = widen(al[2]) - (widen(al3_p1) <<< 1) + widen(al3_p2);
    sum_d = t1 + t2 + t3;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      al2_p  <= 1'b0;
      al3_p1 <= 1'b0;
      al3_p2 <= 1'b0;
      off_o  <= '0;
    end else begin
      al2_p  <= al[1];
      al3_p1 <= al[2];
      al3_p2 <= al3_p1;
      off_o  <= sum_d;
    end
  end
endmodule

// File: rtl/mash_ratio_out.sv
// Adds the signed offset to the base, clamps to the divider window, flags bad bases.
module mash_ratio_out
  import mash_pkg::*;
#(
  parameter int RATIO_W   = 5,
  parameter int RATIO_MIN = 16,
  parameter int RATIO_MAX = 31,
  parameter int BASE_MIN  = 19,
  parameter int BASE_MAX  = 27
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] base_i,
  input  off_t               off_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               sat_o
);
  localparam int SUM_W = RATIO_W + 2;
  localparam logic signed [SUM_W-1:0] LO_S = SUM_W'(RATIO_MIN);
  localparam logic signed [SUM_W-1:0] HI_S = SUM_W'(RATIO_MAX);
  localparam logic [RATIO_W-1:0] LO_R = RATIO_W'(RATIO_MIN);
  localparam logic [RATIO_W-1:0] HI_R = RATIO_W'(RATIO_MAX);
  localparam logic [RATIO_W-1:0] BLO  = RATIO_W'(BASE_MIN);
  localparam logic [RATIO_W-1:0] BHI  = RATIO_W'(BASE_MAX);

  logic signed [SUM_W-1:0] raw;
  logic [RATIO_W-1:0]      clip;
  logic                    bad;

  always_comb begin
    raw = $signed({2'b00, base_i})
        + $signed({{(SUM_W-OFF_W){off_i[OFF_W-1]}}, off_i});
    if (raw < LO_S)      clip = LO_R;
    else if (raw > HI_S) clip = HI_R;
    else                 clip = raw[RATIO_W-1:0];
    bad = (base_i < BLO) || (base_i > BHI);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_o <= LO_R;
      sat_o   <= 1'b0;
    end else begin
      ratio_o <= clip;
      sat_o   <= bad;
    end
  end
endmodule

// File: rtl/mash3_ratio_gen.sv
module mash3_ratio_gen
  import mash_pkg::*;
#(
  parameter int FRAC_W    = 20,
  parameter int RATIO_W   = 5,
  parameter int RATIO_MIN = 16,
  parameter int RATIO_MAX = 31
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FRAC_W-1:0]  frac_i,
  input  logic [RATIO_W-1:0] base_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               sat_o
);
  localparam int BASE_MIN = RATIO_MIN - OFF_MIN;
  localparam int BASE_MAX = RATIO_MAX - OFF_MAX;

  logic [ORDER-1:0] cy;
  off_t             off_q;

  mash_acc_chain #(.W(FRAC_W), .N(ORDER)) u_chain (
    .clk    (clk),
    .rst    (rst),
    .frac_i (frac_i),
    .cy_o   (cy)
  );

  mash_cancel u_cancel (
    .clk   (clk),
    .rst   (rst),
    .cy_i  (cy),
    .off_o (off_q)
  );

  mash_ratio_out #(
    .RATIO_W   (RATIO_W),
    .RATIO_MIN (RATIO_MIN),
    .RATIO_MAX (RATIO_MAX),
    .BASE_MIN  (BASE_MIN),
    .BASE_MAX  (BASE_MAX)
  ) u_out (
    .clk     (clk),
    .rst     (rst),
    .base_i  (base_i),
    .off_i   (off_q),
    .ratio_o (ratio_o),
    .sat_o   (sat_o)
  );
endmodule

// File: rtl/mash3_ratio_gen_chk.sv
module mash3_ratio_gen_chk
  import mash_pkg::*;
#(
  parameter int RATIO_W   = 5,
  parameter int RATIO_MIN = 16,
  parameter int RATIO_MAX = 31
) (
  input logic               clk,
  input logic               rst,
  input logic [RATIO_W-1:0] base_i,
  input logic [RATIO_W-1:0] ratio_o,
  input logic               sat_o,
  input off_t               off_q
);
  localparam int BASE_MIN = RATIO_MIN - OFF_MIN;
  localparam int BASE_MAX = RATIO_MAX - OFF_MAX;

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (int'(ratio_o) == RATIO_MIN && !sat_o));

  assert_offset_span_R3: assert property (@(posedge clk) disable iff (rst)
    (int'(off_q) >= OFF_MIN && int'(off_q) <= OFF_MAX));

  assert_tracks_base_R3: assert property (@(posedge clk) disable iff (rst)
    (!$fell(rst) && !sat_o) |->
      (int'(ratio_o) >= int'($past(base_i)) + OFF_MIN &&
       int'(ratio_o) <= int'($past(base_i)) + OFF_MAX));

  assert_sat_flag_R6: assert property (@(posedge clk) disable iff (rst)
    !$fell(rst) |->
      (sat_o == (int'($past(base_i)) < BASE_MIN || int'($past(base_i)) > BASE_MAX)));

  assert_ratio_window_R7: assert property (@(posedge clk) disable iff (rst)
    (int'(ratio_o) >= RATIO_MIN && int'(ratio_o) <= RATIO_MAX));
endmodule

bind mash3_ratio_gen mash3_ratio_gen_chk #(
  .RATIO_W   (RATIO_W),
  .RATIO_MIN (RATIO_MIN),
  .RATIO_MAX (RATIO_MAX)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .base_i  (base_i),
  .ratio_o (ratio_o),
  .sat_o   (sat_o),
  .off_q   (off_q)
);

// File: tb/sim_mash3_ratio_gen.sv
`timescale 1ns/1ps
module sim_mash3_ratio_gen;
  localparam int NMEAN = 32768;
  localparam logic [19:0] HALF = 20'h80000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] frac = '0;
  logic [4:0]  base = 5'd23;
  logic [4:0]  ratio;
  logic        sat;
  int          total = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  mash3_ratio_gen u0 (
    .clk(clk), .rst(rst), .frac_i(frac), .base_i(base),
    .ratio_o(ratio), .sat_o(sat)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [19:0] f, input logic [4:0] b);
    @(negedge clk);
    rst = 1'b1; frac = f; base = b;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset(HALF, 5'd23);
    repeat (20) step();
    @(negedge clk); rst = 1'b1; base = 5'd5;
    step();
    chk(int'(ratio) == 16, "R1 ratio in reset", int'(ratio), 16);
    chk(sat == 1'b0, "R1 sat in reset", int'(sat), 0);
    rst = 1'b0;
  endtask

  task automatic t_zero_frac();
    bit ok = 1'b1; int bad = 0;
    do_reset('0, 5'd22);
    for (int i = 0; i < 24; i++) begin
      step();
      if (int'(ratio) != 22 || sat) begin ok = 1'b0; bad = int'(ratio); end
    end
    chk(ok, "R2 zero fraction holds base", bad, 22);
  endtask

  task automatic t_base_step();
    do_reset('0, 5'd22);
    repeat (4) step();
    base = 5'd25;
    #1;
    chk(int'(ratio) == 22, "R8 no change before edge", int'(ratio), 22);
    step();
    chk(int'(ratio) == 25, "R8 one edge latency", int'(ratio), 25);
  endtask

  task automatic t_startup_and_period();
    int exp_off[10] = '{0, 0, 0, 0, 0, 2, -1, 1, 0, 2};
    int h[40];
    bit per_ok = 1'b1, sum_ok = 1'b1;
    int per_bad = 0, sum_bad = 2;
    do_reset(HALF, 5'd23);
    for (int i = 0; i < 10; i++) begin
      step();
      chk(int'(ratio) == 23 + exp_off[i], "R9 startup sequence", int'(ratio), 23 + exp_off[i]);
    end
    for (int n = 0; n < 40; n++) begin
      step();
      h[n] = int'(ratio) - 23;
    end
    for (int n = 4; n < 40; n++)
      if (h[n] != h[n-4]) begin per_ok = 1'b0; per_bad = h[n]; end
    for (int n = 3; n < 40; n++)
      if (h[n] + h[n-1] + h[n-2] + h[n-3] != 2) begin
        sum_ok = 1'b0; sum_bad = h[n] + h[n-1] + h[n-2] + h[n-3];
      end
    chk(per_ok, "R5 period 4", per_bad, 0);
    chk(sum_ok, "R5 four-sample sum", sum_bad, 2);
  endtask

  task automatic t_mean(input logic [19:0] f, input logic [4:0] b);
    longint sum = 0;
    real expv, diff;
    bit span_ok = 1'b1; int span_bad = 0;
    do_reset(f, b);
    repeat (8) step();
    for (int i = 0; i < NMEAN; i++) begin
      int o;
      step();
      o = int'(ratio) - int'(b);
      if (o < -3 || o > 4) begin span_ok = 1'b0; span_bad = o; end
      sum += o;
    end
    expv = real'(NMEAN) * real'(f) / 1048576.0;
    diff = real'(sum) - expv;
    if (diff < 0.0) diff = -diff;
    chk(span_ok, "R3 offset span", span_bad, 0);
    chk(diff <= 4.0, "R4 long-run mean", int'(sum), int'(expv));
  endtask

  task automatic t_clamp_sat();
    bit ok = 1'b1; bit hit31 = 1'b0; int bad = 0;
    do_reset(HALF, 5'd2);
    repeat (2) step();
    for (int i = 0; i < 16; i++) begin
      step();
      if (int'(ratio) != 16 || !sat) begin ok = 1'b0; bad = int'(ratio); end
    end
    chk(ok, "R7 low clamp with sat", bad, 16);
    do_reset(HALF, 5'd31);
    repeat (2) step();
    ok = 1'b1;
    for (int i = 0; i < 16; i++) begin
      step();
      if (int'(ratio) == 31) hit31 = 1'b1;
      if (int'(ratio) < 30 || !sat) begin ok = 1'b0; bad = int'(ratio); end
    end
    chk(ok && hit31, "R7 high clamp with sat", bad, 31);
    base = 5'd19; step();
    chk(sat == 1'b0, "R6 base 19 valid", int'(sat), 0);
    base = 5'd18; step();
    chk(sat == 1'b1, "R6 base 18 flagged", int'(sat), 1);
    base = 5'd27; step();
    chk(sat == 1'b0, "R6 base 27 valid", int'(sat), 0);
    base = 5'd28; step();
    chk(sat == 1'b1, "R6 base 28 flagged", int'(sat), 1);
  endtask

  initial begin
    t_reset_state();
    t_zero_frac();
    t_base_step();
    t_startup_and_period();
    t_clamp_sat();
    t_mean(20'h5A5A5, 5'd21);
    t_mean(20'hFFFFF, 5'd27);
    t_mean(20'h00001, 5'd19);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule